// File: doc/BRIEF.md
# Three-Channel Link and Activity LED Controller

The block drives three indicator outputs from the state of an Ethernet link and from traffic events. Each channel owns two 16-bit configuration words. The lit-condition word lists the link states (speed, link down, duplex) that hold the indicator steadily on. The flash-condition word lists the per-speed transmit and receive events, plus collision and receive-error events, that start a flash. Each channel also has an enable, a polarity choice, a forced-on control and a forced-flash control. Three shared words set the global enable, the timer enable, the lit part of a flash and the full flash period.

Link state and events come in on plain control pins. A timebase pulse `tick` advances every flash timer. Software reaches the configuration words through a simple synchronous 16-bit register port. Writes take effect on the clock edge. Reads are combinational from the address. The indicator outputs are registered, so each one follows its inputs with one cycle of latency.

Top module: `led_ctl_top`

## Requirements
- R1: After reset, `led_o` is 3'b111 (every channel off with active-low polarity). The on-time word (0x22) reads 0x0400, the period word (0x23) reads 0x0800, and every other word reads 0.
- R2: Word offsets are: 0x21 global control, 0x22 on-time, 0x23 period, 0x24+2i lit-conditions of channel i, 0x25+2i flash-conditions of channel i. A write stores all 16 bits and reads back unchanged. Any other offset reads 0 and ignores writes.
- R3: `link_speed` is coded as 0=10, 1=100, 2=1000, 3=2500 Mb/s. While the link is up, the channel lights when the lit-condition bit for the current speed is set. Those bits are bit 2, bit 1, bit 0 and bit 8 respectively.
- R4: Lit-condition bit 3 lights the channel while the link is down. Bit 4 lights it while the link is up at full duplex, and bit 5 while it is up at half duplex.
- R5: Lit-condition bit 6 lights the channel whatever the link state.
- R6: A channel whose enable (lit-condition bit 15) is clear drives its inactive level. So does every channel while global control bit 15 is clear.
- R7: Lit-condition bit 14 sets polarity. With 1 the output is high when lit; with 0 the output is low when lit and high when off.
- R8: A flash starts on a link-up transmit or receive pulse at the current speed whose flash bit is set, or on a collision (bit 6), CRC-error (bit 7) or idle-error (bit 8) pulse. The transmit/receive bit pairs are 0/1 at 1000, 2/3 at 100, 4/5 at 10 and 10/11 at 2500. A flash lasts one period; the channel is lit for the first on-time ticks of that period, then off. A flash takes priority over the steady lit state.
- R9: A qualifying event during a running flash does not restart it. It adds exactly one more full period after the current one ends.
- R10: Flash-condition bit 9 repeats flashes back to back for as long as it is set.
- R11: Flash timers advance only on cycles where `tick` is high and global control bit 3 is set. Otherwise a running flash holds its phase.
- R12: `led_o` reflects inputs and configuration one clock edge after they change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word offset |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| tick | input | 1 | Timebase pulse for flash timers |
| link_up | input | 1 | Link is established |
| link_speed | input | 2 | Speed code: 0=10, 1=100, 2=1000, 3=2500 |
| full_duplex | input | 1 | Link runs full duplex |
| tx_pulse | input | 1 | One transmitted frame |
| rx_pulse | input | 1 | One received frame |
| col_pulse | input | 1 | Collision seen |
| crc_err_pulse | input | 1 | Received frame with bad CRC |
| idle_err_pulse | input | 1 | Receive idle error |
| led_o | output | 3 | Indicator drive, one bit per channel |

## Verification
The state that can go wrong here is the flash timer of each channel: its running flag, its tick counter and its pending extension. A stuck or miscounted timer shows at `led_o` within one flash period, as lit and dark phases of the wrong length or a flash that never ends. A dropped or wrongly restarted extension shows at `led_o` within the second period, as a pattern that differs from on-off-on-off. Faults in the configuration decode show at the output one edge after the register write or input change that exercises them.

// File: rtl/led_ctl_pkg.sv
package led_ctl_pkg;
  typedef enum logic [1:0] {
    SPD_10   = 2'd0,
    SPD_100  = 2'd1,
    SPD_1000 = 2'd2,
    SPD_2500 = 2'd3
  } spd_e;

  localparam int unsigned OFS_CTRL  = 'h21;
  localparam int unsigned OFS_ONT   = 'h22;
  localparam int unsigned OFS_PER   = 'h23;
  localparam int unsigned OFS_CH0   = 'h24;

  localparam logic [15:0] ONT_RESET = 16'h0400;
  localparam logic [15:0] PER_RESET = 16'h0800;

  localparam int unsigned CTL_EXT   = 15;
  localparam int unsigned CTL_TMR   = 3;
  localparam int unsigned LIT_EN    = 15;
  localparam int unsigned LIT_POL   = 14;
  localparam int unsigned LIT_FORCE = 6;
  localparam int unsigned FL_FORCE  = 9;
endpackage

// File: rtl/led_ctl_regs.sv
module led_ctl_regs
  import led_ctl_pkg::*;
#(
  parameter int NLED = 3,
  parameter int AW   = 6,
  parameter int DW   = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [AW-1:0]             addr,
  input  logic [DW-1:0]             wdata,
  output logic [DW-1:0]             rdata,
  output logic                      ext_en,
  output logic                      tmr_en,
  output logic [DW-1:0]             on_time,
  output logic [DW-1:0]             period,
  output logic [NLED-1:0][DW-1:0]   lit_cfg,
  output logic [NLED-1:0][DW-1:0]   fl_cfg
);
  logic [DW-1:0] ctrl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      on_time <= DW'(ONT_RESET);
      period  <= DW'(PER_RESET);
      lit_cfg <= '0;
      fl_cfg  <= '0;
    end else if (we) begin
      if (addr == AW'(OFS_CTRL)) ctrl_q  <= wdata;
      if (addr == AW'(OFS_ONT))  on_time <= wdata;
      if (addr == AW'(OFS_PER))  period  <= wdata;
      for (int i = 0; i < NLED; i++) begin
        if (addr == AW'(OFS_CH0 + 2*i))     lit_cfg[i] <= wdata;
        if (addr == AW'(OFS_CH0 + 2*i + 1)) fl_cfg[i]  <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == AW'(OFS_CTRL)) rdata = ctrl_q;
    if (addr == AW'(OFS_ONT))  rdata = on_time;
    if (addr == AW'(OFS_PER))  rdata = period;
    for (int i = 0; i < NLED; i++) begin
      if (addr == AW'(OFS_CH0 + 2*i))     rdata = lit_cfg[i];
      if (addr == AW'(OFS_CH0 + 2*i + 1)) rdata = fl_cfg[i];
    end
  end

  assign ext_en = ctrl_q[CTL_EXT];
  assign tmr_en = ctrl_q[CTL_TMR];
endmodule

// File: rtl/led_ctl_cond.sv
module led_ctl_cond
  import led_ctl_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          link_up,
  input  spd_e          speed,
  input  logic          full_duplex,
  input  logic          tx_pulse,
  input  logic          rx_pulse,
  input  logic          col_pulse,
  input  logic          crc_pulse,
  input  logic          idle_pulse,
  input  logic [DW-1:0] lit_cfg,
  input  logic [DW-1:0] fl_cfg,
  output logic          steady,
  output logic          hit,
  output logic          force_fl,
  output logic          chan_en,
  output logic          polarity
);
  logic spd_lit, tx_sel, rx_sel;
  logic cfg_unused;

  always_comb begin
    unique case (speed)
      SPD_10:   begin spd_lit = lit_cfg[2]; tx_sel = fl_cfg[4];  rx_sel = fl_cfg[5];  end
      SPD_100:  begin spd_lit = lit_cfg[1]; tx_sel = fl_cfg[2];  rx_sel = fl_cfg[3];  end
      SPD_1000: begin spd_lit = lit_cfg[0]; tx_sel = fl_cfg[0];  rx_sel = fl_cfg[1];  end
      default:  begin spd_lit = lit_cfg[8]; tx_sel = fl_cfg[10]; rx_sel = fl_cfg[11]; end
    endcase
  end

  assign steady = lit_cfg[LIT_FORCE]
                | (link_up & spd_lit)
                | (!link_up & lit_cfg[3])
                | (link_up & full_duplex & lit_cfg[4])
                | (link_up & !full_duplex & lit_cfg[5]);

  assign hit = (link_up & ((tx_pulse & tx_sel) | (rx_pulse & rx_sel)))
             | (col_pulse & fl_cfg[6])
             | (crc_pulse & fl_cfg[7])
             | (idle_pulse & fl_cfg[8]);

  assign force_fl = fl_cfg[FL_FORCE];
  assign chan_en  = lit_cfg[LIT_EN];
  assign polarity = lit_cfg[LIT_POL];
  assign cfg_unused = ^{lit_cfg[13:9], lit_cfg[7], fl_cfg[DW-1:12]};
endmodule

// File: rtl/led_ctl_flash.sv
module led_ctl_flash #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          hit,
  input  logic          force_fl,
  input  logic [DW-1:0] on_time,
  input  logic [DW-1:0] period,
  output logic          active,
  output logic [DW-1:0] cnt,
  output logic          phase_on
);
  logic pend;
  logic last;

  assign last = ({1'b0, cnt} + (DW+1)'(1)) >= {1'b0, period};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      pend   <= 1'b0;
    end else if (!active) begin
      if (hit || force_fl) begin
        active <= 1'b1;
        cnt    <= '0;
        pend   <= 1'b0;
      end
    end else begin
      if (hit) pend <= 1'b1;
      if (step) begin
        if (last) begin
          cnt  <= '0;
          pend <= 1'b0;
          if (!(pend || hit || force_fl)) active <= 1'b0;
        end else begin
          cnt <= cnt + DW'(1);
        end
      end
    end
  end

  assign phase_on = active && (cnt < on_time);
endmodule

// File: rtl/led_ctl_top.sv
module led_ctl_top
  import led_ctl_pkg::*;
#(
  parameter int NLED = 3,
  parameter int AW   = 6,
  parameter int DW   = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [AW-1:0]   reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic            tick,
  input  logic            link_up,
  input  logic [1:0]      link_speed,
  input  logic            full_duplex,
  input  logic            tx_pulse,
  input  logic            rx_pulse,
  input  logic            col_pulse,
  input  logic            crc_err_pulse,
  input  logic            idle_err_pulse,
  output logic [NLED-1:0] led_o
);
  logic                    ext_en, tmr_en, step;
  logic [DW-1:0]           on_time, period;
  logic [NLED-1:0][DW-1:0] lit_cfg, fl_cfg;
  logic [NLED-1:0]         fl_active, led_nxt;
  logic [NLED-1:0][DW-1:0] fl_cnt;

  led_ctl_regs #(.NLED(NLED), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .ext_en(ext_en), .tmr_en(tmr_en),
    .on_time(on_time), .period(period), .lit_cfg(lit_cfg), .fl_cfg(fl_cfg)
  );

  assign step = tick & tmr_en;

  for (genvar i = 0; i < NLED; i++) begin : g_ch
    logic steady, hit, force_fl, chan_en, pol, phase_on, lit, drive;

    led_ctl_cond #(.DW(DW)) u_cond (
      .link_up(link_up), .speed(spd_e'(link_speed)), .full_duplex(full_duplex),
      .tx_pulse(tx_pulse), .rx_pulse(rx_pulse), .col_pulse(col_pulse),
      .crc_pulse(crc_err_pulse), .idle_pulse(idle_err_pulse),
      .lit_cfg(lit_cfg[i]), .fl_cfg(fl_cfg[i]),
      .steady(steady), .hit(hit), .force_fl(force_fl),
      .chan_en(chan_en), .polarity(pol)
    );

    led_ctl_flash #(.DW(DW)) u_flash (
      .clk(clk), .rst_n(rst_n), .step(step), .hit(hit), .force_fl(force_fl),
      .on_time(on_time), .period(period), .active(fl_active[i]),
      .cnt(fl_cnt[i]), .phase_on(phase_on)
    );

    assign lit        = fl_active[i] ? phase_on : steady;
    assign drive      = ext_en & chan_en & lit;
    assign led_nxt[i] = pol ? drive : !drive;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) led_o <= '1;
    else        led_o <= led_nxt;
  end
endmodule

// File: rtl/led_ctl_chk.sv
module led_ctl_chk #(
  parameter int NLED = 3,
  parameter int AW   = 6,
  parameter int DW   = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    reg_we,
  input logic [AW-1:0]           reg_addr,
  input logic [DW-1:0]           reg_wdata,
  input logic                    ext_en,
  input logic                    step,
  input logic [DW-1:0]           on_time,
  input logic [NLED-1:0][DW-1:0] lit_cfg,
  input logic [NLED-1:0]         fl_active,
  input logic [NLED-1:0][DW-1:0] fl_cnt,
  input logic [NLED-1:0]         led_o
);
  p_ontime_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == AW'('h22)) |=> on_time == $past(reg_wdata));

  for (genvar i = 0; i < NLED; i++) begin : g_p
    p_off_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(ext_en && lit_cfg[i][15]) |=> led_o[i] == !$past(lit_cfg[i][14]));

    p_forced_lit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_en && lit_cfg[i][15] && lit_cfg[i][6] && !fl_active[i])
        |=> led_o[i] == $past(lit_cfg[i][14]));

    p_idle_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !fl_active[i] |-> fl_cnt[i] == '0);

    p_hold_phase_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_active[i] && !step) |=> $stable(fl_cnt[i]));
  end
endmodule

bind led_ctl_top led_ctl_chk #(.NLED(NLED), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .ext_en(ext_en), .step(step), .on_time(on_time),
  .lit_cfg(lit_cfg), .fl_active(fl_active), .fl_cnt(fl_cnt), .led_o(led_o)
);

// File: tb/led_ctl_top_bench.sv
module led_ctl_top_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        tick = 1'b1;
  logic        link_up = 1'b1;
  logic [1:0]  link_speed = 2'd2;
  logic        full_duplex = 1'b1;
  logic        tx_pulse = 1'b0, rx_pulse = 1'b0, col_pulse = 1'b0;
  logic        crc_err_pulse = 1'b0, idle_err_pulse = 1'b0;
  logic [2:0]  led_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  led_ctl_top u_led_ctl_top (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick(tick),
    .link_up(link_up), .link_speed(link_speed), .full_duplex(full_duplex),
    .tx_pulse(tx_pulse), .rx_pulse(rx_pulse), .col_pulse(col_pulse),
    .crc_err_pulse(crc_err_pulse), .idle_err_pulse(idle_err_pulse),
    .led_o(led_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic set_evt(input int sel, input logic v);
    case (sel)
      0: tx_pulse = v;
      1: rx_pulse = v;
      2: col_pulse = v;
      3: crc_err_pulse = v;
      default: idle_err_pulse = v;
    endcase
  endtask

  task automatic t_reset();
    logic [15:0] d;
    check("R1 led reset", led_o, 3'b111);
    rd(6'h22, d); check("R1 on-time reset", d, 16'h0400);
    rd(6'h23, d); check("R1 period reset", d, 16'h0800);
    rd(6'h21, d); check("R1 ctrl reset", d, 0);
    rd(6'h26, d); check("R1 channel word reset", d, 0);
  endtask

  task automatic t_regs();
    logic [15:0] d;
    wr(6'h25, 16'h0A5A); rd(6'h25, d); check("R2 flash word readback", d, 16'h0A5A);
    wr(6'h29, 16'h0C03); rd(6'h29, d); check("R2 last flash word readback", d, 16'h0C03);
    wr(6'h25, 16'h0000);
    wr(6'h29, 16'h0000);
    wr(6'h30, 16'hFFFF); rd(6'h30, d); check("R2 unmapped reads zero", d, 0);
    rd(6'h28, d); check("R2 unmapped write ignored", d, 0);
  endtask

  task automatic t_speed();
    int bitpos[4] = '{2, 1, 0, 8};
    wr(6'h21, 16'h8008);
    link_up = 1'b1;
    for (int s = 0; s < 4; s++) begin
      wr(6'h28, 16'hC000 | (16'h1 << bitpos[s]));
      for (int p = 0; p < 4; p++) begin
        link_speed = 2'(p);
        settle();
        check($sformatf("R3 speed cfg %0d at code %0d", s, p), led_o[2], (p == s));
      end
    end
  endtask

  task automatic t_down_dup();
    wr(6'h28, 16'hC008);
    link_up = 1'b0; settle(); check("R4 link-down lit", led_o[2], 1);
    link_up = 1'b1; settle(); check("R4 link-down dark when up", led_o[2], 0);
    wr(6'h28, 16'hC010);
    full_duplex = 1'b1; settle(); check("R4 full duplex lit", led_o[2], 1);
    full_duplex = 1'b0; settle(); check("R4 full duplex dark at half", led_o[2], 0);
    link_up = 1'b0; full_duplex = 1'b1; settle(); check("R4 duplex needs link", led_o[2], 0);
    link_up = 1'b1;
    wr(6'h28, 16'hC020);
    full_duplex = 1'b0; settle(); check("R4 half duplex lit", led_o[2], 1);
    full_duplex = 1'b1; settle(); check("R4 half duplex dark at full", led_o[2], 0);
  endtask

  task automatic t_force_pol();
    link_up = 1'b0;
    wr(6'h28, 16'hC040); settle(); check("R5 forced on, high polarity", led_o[2], 1);
    wr(6'h28, 16'h8040); settle(); check("R7 forced on, low polarity", led_o[2], 0);
    wr(6'h28, 16'h8000); settle(); check("R7 off, low polarity", led_o[2], 1);
    link_up = 1'b1;
  endtask

  task automatic t_enable();
    wr(6'h28, 16'h4040); settle(); check("R6 disabled high polarity", led_o[2], 0);
    wr(6'h28, 16'h0040); settle(); check("R6 disabled low polarity", led_o[2], 1);
    wr(6'h28, 16'hC040);
    wr(6'h21, 16'h0008); settle(); check("R6 global enable clear", led_o[2], 0);
    wr(6'h21, 16'h8008); settle(); check("R6 global enable set", led_o[2], 1);
  endtask

  task automatic t_latency();
    wr(6'h28, 16'hC001);
    link_speed = 2'd1; settle();
    @(negedge clk);
    link_speed = 2'd2;
    #1 check("R12 no change before edge", led_o[2], 0);
    @(negedge clk);
    check("R12 change after one edge", led_o[2], 1);
  endtask

  task automatic t_flash(input string req, input int sel, input logic [1:0] spd,
                         input logic [15:0] flcfg, input bit extend,
                         input logic [7:0] exp);
    link_speed = spd;
    wr(6'h22, 16'd2);
    wr(6'h23, 16'd4);
    wr(6'h24, 16'hC000);
    wr(6'h25, flcfg);
    @(negedge clk); set_evt(sel, 1'b1);
    @(negedge clk); set_evt(sel, 1'b0);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check($sformatf("%s sample %0d", req, k), led_o[0], exp[7-k]);
      set_evt(sel, (extend && k == 0));
    end
    settle();
    check({req, " ends dark"}, led_o[0], 0);
  endtask

  task automatic t_force_flash();
    int ones = 0;
    wr(6'h26, 16'hC000);
    wr(6'h27, 16'h0200);
    repeat (3) @(negedge clk);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (led_o[1]) ones++;
    end
    check("R10 forced flash lit count", ones, 6);
    wr(6'h27, 16'h0000);
    repeat (8) @(negedge clk);
    check("R10 forced flash stops", led_o[1], 0);
  endtask

  task automatic t_tick_gate();
    int ones = 0;
    link_speed = 2'd2;
    wr(6'h25, 16'h0001);
    wr(6'h21, 16'h8000);
    @(negedge clk); tx_pulse = 1'b1;
    @(negedge clk); tx_pulse = 1'b0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (led_o[0]) ones++;
    end
    check("R11 phase held without timer enable", ones, 10);
    wr(6'h21, 16'h8008);
    repeat (8) @(negedge clk);
    check("R11 flash completes after enable", led_o[0], 0);
    tick = 1'b0;
    @(negedge clk); tx_pulse = 1'b1;
    @(negedge clk); tx_pulse = 1'b0;
    repeat (8) @(negedge clk);
    check("R11 phase held without tick", led_o[0], 1);
    tick = 1'b1;
    repeat (8) @(negedge clk);
    check("R11 flash completes with tick", led_o[0], 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_speed();
    t_down_dup();
    t_force_pol();
    t_enable();
    t_latency();
    t_flash("R8 tx at 1000", 0, 2'd2, 16'h0001, 1'b0, 8'b1100_0000);
    t_flash("R8 rx at 100", 1, 2'd1, 16'h0008, 1'b0, 8'b1100_0000);
    t_flash("R8 tx at 2500", 0, 2'd3, 16'h0400, 1'b0, 8'b1100_0000);
    t_flash("R8 collision", 2, 2'd0, 16'h0040, 1'b0, 8'b1100_0000);
    t_flash("R8 crc error", 3, 2'd0, 16'h0080, 1'b0, 8'b1100_0000);
    t_flash("R8 idle error", 4, 2'd0, 16'h0100, 1'b0, 8'b1100_0000);
    t_flash("R8 unselected speed ignored", 0, 2'd1, 16'h0001, 1'b0, 8'b0000_0000);
    t_flash("R9 extension", 0, 2'd2, 16'h0001, 1'b1, 8'b1100_1100);
    t_force_flash();
    t_tick_gate();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule